// File: doc/BRIEF.md
# Preload Up-Down Address Counter

This block holds the memory address of a small microcoded processor. It is a register as wide as the address that can be preloaded from a register value chosen elsewhere. It can also step by one, up or down. Its output drives the memory address bus directly.

Within one control step the counter works in two phases. Once the control word has settled, a count request acts straight away on the address the block drives. A memory read made later in the same step therefore sees the advanced address. The clock edge that ends the step is the capture phase. At that edge the register keeps the advanced address, or takes the preload value.

A preload is therefore visible only from the next step onward, while a count shows in the step that asks for it. All control pins are plain levels sampled once per step. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `preload_addr_counter`

## Requirements
- R1: With `rst_i` high at a clock edge, the stored address becomes 0x0000. In the next step with no control bits set, `addr_o` reads 0x0000.
- R2: With `load_i` high in a step, the stored address takes `load_val_i` at the closing edge. `addr_o` shows the old stored address during that step and the loaded value from the next step on.
- R3: With `count_i` high, `up_i` high and `load_i` low, `addr_o` shows the stored address plus one within the same step. That value is also stored at the closing edge.
- R4: With `count_i` high, `up_i` low and `load_i` low, `addr_o` shows the stored address minus one within the same step. That value is also stored at the closing edge.
- R5: Counting wraps modulo 2^16. Up from 0xFFFF gives 0x0000, and down from 0x0000 gives 0xFFFF.
- R6: With `load_i` and `count_i` both high, the load wins. `addr_o` does not step in that step, and the loaded value is stored.
- R7: With `load_i` and `count_i` both low, `addr_o` holds the stored address unchanged from step to step.
- R8: A preload of 0x0000 followed by count-up in consecutive steps gives the address sequence 0x0000, 0x0001, 0x0002, 0x0003, one step per value.
- R9: While `count_i` is low, `up_i` has no effect on `addr_o` or on the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock; rising edge is the capture phase |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Preload request |
| count_i | input | 1 | Count request |
| up_i | input | 1 | Count direction: 1 up, 0 down |
| load_val_i | input | 16 | Value to preload |
| addr_o | output | 16 | Memory address for the current step |

## Verification
Preload and count can both be asked for in the same step. This is the one collision inside the block. The bench forces it by holding `load_i` and `count_i` high together, in both directions, from stored addresses that sit at a wrap point. It judges the result in two places. During that step `addr_o` must not have moved. In the following idle step it must equal the preload value, not a stepped value.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;
  // Operation selected for one control step.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } step_op_e;
endpackage

// File: rtl/addr_ctr_decode.sv
module addr_ctr_decode
  import addr_ctr_pkg::*;
(
  input  logic     load_i,
  input  logic     count_i,
  input  logic     up_i,
  output step_op_e op_o
);
  // Load outranks count; direction matters only while counting.
  always_comb begin
    if (load_i)       op_o = OP_LOAD;
    else if (count_i) op_o = up_i ? OP_INC : OP_DEC;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/addr_ctr_step.sv
module addr_ctr_step
  import addr_ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] stored_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  step_op_e         op_i,
  output logic [WIDTH-1:0] show_o,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Pre-capture phase: the count is applied to the driven address.
  always_comb begin
    unique case (op_i)
      OP_INC:  show_o = stored_i + ONE;
      OP_DEC:  show_o = stored_i - ONE;
      default: show_o = stored_i;
    endcase
  end

  // Capture phase: preload replaces, otherwise keep what was shown.
  always_comb begin
    next_o = (op_i == OP_LOAD) ? load_val_i : show_o;
  end
endmodule

// File: rtl/addr_ctr_reg.sv
module addr_ctr_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/preload_addr_counter.sv
module preload_addr_counter
  import addr_ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic             count_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] addr_o
);
  step_op_e         op;
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] show;
  logic [WIDTH-1:0] next;

  addr_ctr_decode u_dec (
    .load_i (load_i),
    .count_i(count_i),
    .up_i   (up_i),
    .op_o   (op)
  );

  addr_ctr_step #(.WIDTH(WIDTH)) u_step (
    .stored_i  (stored),
    .load_val_i(load_val_i),
    .op_i      (op),
    .show_o    (show),
    .next_o    (next)
  );

  addr_ctr_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  (next),
    .q_o  (stored)
  );

  assign addr_o = show;
endmodule

// File: rtl/preload_addr_counter_chk.sv
module preload_addr_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             load_i,
  input logic             count_i,
  input logic             up_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] addr_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1: first idle step after reset shows zero
  a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i) && !load_i && !count_i) |-> (addr_o == '0));

  // R2 and R6: a preload is seen in the next idle step
  a_r2_load_seen: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(load_i && !rst_i) && !load_i && !count_i) |-> (addr_o == $past(load_val_i)));

  // R3 and R5: count-up advances the shown address by one, modulo width
  a_r3_count_up: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_i && up_i && !load_i && $past(!rst_i && !load_i)) |-> (addr_o == $past(addr_o) + ONE));

  // R4 and R5: count-down retreats by one, modulo width
  a_r4_count_down: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_i && !up_i && !load_i && $past(!rst_i && !load_i)) |-> (addr_o == $past(addr_o) - ONE));

  // R7 and R9: idle steps hold the address
  a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!count_i && !load_i && $past(!rst_i && !load_i)) |-> (addr_o == $past(addr_o)));
endmodule

bind preload_addr_counter preload_addr_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .load_i    (load_i),
  .count_i   (count_i),
  .up_i      (up_i),
  .load_val_i(load_val_i),
  .addr_o    (addr_o)
);

// File: tb/sim_preload_addr_counter.sv
`timescale 1ns/1ps
module sim_preload_addr_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld = 1'b0, cnt = 1'b0, up = 1'b0;
  logic [15:0] val = '0;
  logic [15:0] addr;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  preload_addr_counter u0 (
    .clk_i(clk), .rst_i(rst), .load_i(ld), .count_i(cnt),
    .up_i(up), .load_val_i(val), .addr_o(addr)
  );

  // Set controls after a falling edge, let the logic settle. The rising edge follows later.
  task automatic drive(input logic l, input logic c, input logic u, input logic [15:0] v);
    @(negedge clk);
    ld = l; cnt = c; up = u; val = v;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (addr !== exp) begin
      n_fail++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  task automatic preload(input logic [15:0] v);
    drive(1, 0, 0, v);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(1, 1, 1, 16'h5A5A);
    drive(0, 0, 0, 16'h0);
    @(negedge clk); rst = 1'b0;
    drive(0, 0, 0, 16'h0);
    check("R1 reset", 16'h0000);
  endtask

  task automatic t_load;
    preload(16'h1234);
    check("R2 old value during load", 16'h0000);
    drive(0, 0, 0, 16'hFFFF);
    check("R2 loaded", 16'h1234);
  endtask

  task automatic t_up_seq;
    preload(16'h0000);
    drive(0, 0, 0, 16'h0);
    check("R8 start", 16'h0000);
    drive(0, 1, 1, 16'h0);
    check("R8 step1 R3 same step", 16'h0001);
    drive(0, 1, 1, 16'h0);
    check("R8 step2", 16'h0002);
    drive(0, 1, 1, 16'h0);
    check("R8 step3", 16'h0003);
    drive(0, 0, 0, 16'h0);
    check("R3 stored", 16'h0003);
  endtask

  task automatic t_down;
    preload(16'h0100);
    drive(0, 1, 0, 16'h0);
    check("R4 same step", 16'h00FF);
    drive(0, 1, 0, 16'h0);
    check("R4 second", 16'h00FE);
    drive(0, 0, 0, 16'h0);
    check("R4 stored", 16'h00FE);
  endtask

  task automatic t_wrap;
    preload(16'hFFFF);
    drive(0, 1, 1, 16'h0);
    check("R5 up wrap", 16'h0000);
    drive(0, 1, 0, 16'h0);
    check("R5 down wrap", 16'hFFFF);
    drive(0, 0, 0, 16'h0);
    check("R5 stored", 16'hFFFF);
  endtask

  task automatic t_priority;
    preload(16'hFFFF);
    drive(1, 1, 1, 16'h0042);
    check("R6 no step up", 16'hFFFF);
    drive(0, 0, 0, 16'h0);
    check("R6 load wins up", 16'h0042);
    preload(16'h0000);
    drive(1, 1, 0, 16'hBEEF);
    check("R6 no step down", 16'h0000);
    drive(0, 0, 0, 16'h0);
    check("R6 load wins down", 16'hBEEF);
  endtask

  task automatic t_hold;
    preload(16'h7777);
    drive(0, 0, 0, 16'h1111);
    check("R7 hold a", 16'h7777);
    drive(0, 0, 0, 16'h2222);
    check("R7 hold b", 16'h7777);
  endtask

  task automatic t_up_ignored;
    preload(16'h4000);
    drive(0, 0, 1, 16'h0);
    check("R9 up alone", 16'h4000);
    drive(0, 0, 0, 16'h0);
    check("R9 stored kept", 16'h4000);
  endtask

  initial begin
    fork
      begin
        t_reset; t_load; t_up_seq; t_down; t_wrap; t_priority; t_hold; t_up_ignored;
      end
      begin
        repeat (2000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule